// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This block checks data integrity for one transfer channel. The channel hands it one byte per valid cycle over the course of a block. A 3-bit mode picks the algorithm. The choices are two fixed 16-bit CRCs, a fixed 32-bit CRC, a 16-bit or 32-bit CRC whose polynomial comes from one of two polynomial inputs, or the 16-bit one's-complement Internet header checksum. Three independent option bits control the CRC: reversing each input byte, reversing the result across its width, and inverting the result.

A start pulse re-seeds the engine and captures the mode, options and polynomial inputs. Changes to those inputs after that point have no effect until the next start. Every CRC is computed MSB-first and consumes one byte per clock. The shaped result is always visible on `result`. `result_valid` pulses in the cycle after the byte marked last has been taken. While the channel enable is low, the engine ignores every input and holds its result.

Top module: `crc_engine`

## Requirements
- R1: Mode 3'b000 gives a 16-bit CRC with polynomial 0x8005. Mode 3'b001 gives a 16-bit CRC with polynomial 0x1021. Mode 3'b100 gives a 32-bit CRC with polynomial 0x04C11DB7. All three are MSB-first, and each is seeded with all ones at start.
- R2: Modes 3'b010 and 3'b011 give a 16-bit CRC that uses bits 15:0 of `poly_a` and `poly_b` respectively. Modes 3'b101 and 3'b110 give a 32-bit CRC that uses all of `poly_a` and `poly_b` respectively. All four are seeded with all ones.
- R3: Mode 3'b111 gives the Internet checksum. Bytes pair big-endian into 16-bit words, and the first byte of each pair is the high byte. The words are summed with end-around carry from a seed of zero. A trailing odd byte gets a zero low byte. The result is the one's complement of the sum in bits 15:0. The three option bits have no effect in this mode.
- R4: With `cfg_refl_in`=1, each byte is bit-reversed before it enters a CRC. With `cfg_refl_in`=0, bytes enter unchanged.
- R5: With `cfg_refl_out`=1, the CRC value is bit-reversed across its full width of 16 or 32 bits.
- R6: With `cfg_xor_out`=1, the CRC value is inverted across its width. The inversion is applied after any output reversal.
- R7: In every 16-bit mode and in checksum mode, `result[31:16]` reads zero.
- R8: A start pulse (`start`=1 while `crc_en`=1) captures the mode, options and both polynomials, and re-seeds the engine. Changes to those inputs at any other time have no effect on the block in progress. A byte presented in the same cycle as start is dropped.
- R9: `result_valid` is 1 in exactly those cycles that directly follow an accepted byte with `byte_last`=1. The result of that block is on `result` in the same cycle.
- R10: While `crc_en`=0, `start` and bytes are ignored, `result` holds its value and `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | Channel CRC enable; the engine is idle when low |
| start | input | 1 | Seed pulse; captures the configuration |
| cfg_mode | input | 3 | Algorithm select |
| cfg_refl_in | input | 1 | Reverse each input byte (CRC modes) |
| cfg_refl_out | input | 1 | Reverse the result across its width (CRC modes) |
| cfg_xor_out | input | 1 | Invert the result (CRC modes) |
| poly_a | input | 32 | Programmable polynomial A |
| poly_b | input | 32 | Programmable polynomial B |
| byte_valid | input | 1 | A data byte is presented |
| byte_data | input | 8 | Data byte |
| byte_last | input | 1 | The presented byte ends the block |
| result | output | 32 | Shaped CRC or checksum |
| result_valid | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions check the following on every cycle:
- the timing of `result_valid` against accepted last bytes;
- the zero upper half in narrow modes;
- the seed values loaded by a start pulse;
- that the captured configuration is held between starts;
- that the engine is frozen while disabled.

The numeric results can be shown only by the bench's scenarios. These cover every mode and every combination of options, the odd-length and carry cases of the checksum, textbook check values, configuration changes in the middle of a block, and bytes offered while disabled.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int FULL_W = 32;

  typedef enum logic [2:0] {
    MD_C16_IBM   = 3'b000,
    MD_C16_CCITT = 3'b001,
    MD_C16_PA    = 3'b010,
    MD_C16_PB    = 3'b011,
    MD_C32_STD   = 3'b100,
    MD_C32_PA    = 3'b101,
    MD_C32_PB    = 3'b110,
    MD_IPCSUM    = 3'b111
  } crc_mode_e;

  typedef struct packed {
    logic              refl_in;
    logic              refl_out;
    logic              xor_out;
    logic              wide;
    logic              is_csum;
    logic [FULL_W-1:0] poly;
  } crc_cfg_t;

  function automatic logic [BYTE_W-1:0] bitrev8(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] bitrev16(input logic [HALF_W-1:0] d);
    logic [HALF_W-1:0] r;
    for (int i = 0; i < HALF_W; i++) r[i] = d[HALF_W-1-i];
    return r;
  endfunction

  function automatic logic [FULL_W-1:0] bitrev32(input logic [FULL_W-1:0] d);
    logic [FULL_W-1:0] r;
    for (int i = 0; i < FULL_W; i++) r[i] = d[FULL_W-1-i];
    return r;
  endfunction

  // Turns the raw mode and option inputs into the captured configuration.
  function automatic crc_cfg_t decode_cfg(
    input logic [2:0]        md,
    input logic              ri,
    input logic              ro,
    input logic              xo,
    input logic [FULL_W-1:0] pa,
    input logic [FULL_W-1:0] pb,
    input logic [HALF_W-1:0] p16_ibm,
    input logic [HALF_W-1:0] p16_ccitt,
    input logic [FULL_W-1:0] p32_std
  );
    crc_cfg_t c;
    c.refl_in  = ri;
    c.refl_out = ro;
    c.xor_out  = xo;
    c.wide     = 1'b0;
    c.is_csum  = 1'b0;
    c.poly     = '0;
    case (crc_mode_e'(md))
      MD_C16_IBM:   c.poly = {16'h0, p16_ibm};
      MD_C16_CCITT: c.poly = {16'h0, p16_ccitt};
      MD_C16_PA:    c.poly = {16'h0, pa[HALF_W-1:0]};
      MD_C16_PB:    c.poly = {16'h0, pb[HALF_W-1:0]};
      MD_C32_STD:   begin c.poly = p32_std; c.wide = 1'b1; end
      MD_C32_PA:    begin c.poly = pa;      c.wide = 1'b1; end
      MD_C32_PB:    begin c.poly = pb;      c.wide = 1'b1; end
      default:      c.is_csum = 1'b1;
    endcase
    return c;
  endfunction

  // One byte through an MSB-first CRC, unrolled over eight bit steps.
  function automatic logic [FULL_W-1:0] crc_byte_step(
    input logic [FULL_W-1:0] st,
    input logic [BYTE_W-1:0] din,
    input logic [FULL_W-1:0] poly,
    input logic              wide
  );
    logic [FULL_W-1:0] s;
    logic              top;
    s = st;
    if (wide) s[FULL_W-1 -: BYTE_W] = s[FULL_W-1 -: BYTE_W] ^ din;
    else      s[HALF_W-1 -: BYTE_W] = s[HALF_W-1 -: BYTE_W] ^ din;
    for (int k = 0; k < BYTE_W; k++) begin
      if (wide) begin
        top = s[FULL_W-1];
        s   = {s[FULL_W-2:0], 1'b0} ^ (top ? poly : '0);
      end else begin
        top = s[HALF_W-1];
        s   = {16'h0, s[HALF_W-2:0], 1'b0} ^ (top ? {16'h0, poly[HALF_W-1:0]} : '0);
      end
    end
    return s;
  endfunction

  // 16-bit one's-complement addition with end-around carry.
  function automatic logic [HALF_W-1:0] ones_add16(
    input logic [HALF_W-1:0] a,
    input logic [HALF_W-1:0] b
  );
    logic [HALF_W:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[HALF_W-1:0] + {15'h0, t[HALF_W]};
  endfunction

endpackage

// File: rtl/crc_cfg_latch.sv
module crc_cfg_latch
  import crc_eng_pkg::*;
#(
  parameter crc_cfg_t RESET_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  crc_cfg_t cfg_d,
  output crc_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= RESET_CFG;
    else if (load) cfg_q <= cfg_d;
  end

endmodule

// File: rtl/crc_shift_lane.sv
module crc_shift_lane
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              seed_wide,
  input  logic              step,
  input  logic              wide,
  input  logic [FULL_W-1:0] poly,
  input  logic [BYTE_W-1:0] din,
  output logic [FULL_W-1:0] state_q
);

  localparam logic [FULL_W-1:0] SEED_WIDE   = '1;
  localparam logic [FULL_W-1:0] SEED_NARROW = {{(FULL_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [FULL_W-1:0] state_nx;

  always_comb begin
    state_nx = state_q;
    if (seed)      state_nx = seed_wide ? SEED_WIDE : SEED_NARROW;
    else if (step) state_nx = crc_byte_step(state_q, din, poly, wide);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_nx;
  end

endmodule

// File: rtl/csum_lane.sv
module csum_lane
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              step,
  input  logic [BYTE_W-1:0] din,
  output logic [HALF_W-1:0] sum_q,
  output logic              odd_q,
  output logic [HALF_W-1:0] final_sum
);

  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      odd_q  <= 1'b0;
      hold_q <= '0;
    end else if (seed) begin
      sum_q  <= '0;
      odd_q  <= 1'b0;
      hold_q <= '0;
    end else if (step) begin
      if (!odd_q) begin
        hold_q <= din;
        odd_q  <= 1'b1;
      end else begin
        sum_q <= ones_add16(sum_q, {hold_q, din});
        odd_q <= 1'b0;
      end
    end
  end

  // A pending high byte is folded in with a zero low byte.
  always_comb begin
    if (odd_q) final_sum = ~ones_add16(sum_q, {hold_q, {BYTE_W{1'b0}}});
    else       final_sum = ~sum_q;
  end

endmodule

// File: rtl/crc_result_shaper.sv
module crc_result_shaper
  import crc_eng_pkg::*;
(
  input  crc_cfg_t          cfg,
  input  logic [FULL_W-1:0] crc_state,
  input  logic [HALF_W-1:0] csum_final,
  output logic [FULL_W-1:0] result
);

  logic [FULL_W-1:0] refl_val;
  logic [FULL_W-1:0] width_mask;

  assign width_mask = cfg.wide ? '1 : {{(FULL_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  always_comb begin
    if (!cfg.refl_out)  refl_val = crc_state & width_mask;
    else if (cfg.wide)  refl_val = bitrev32(crc_state);
    else                refl_val = {{(FULL_W-HALF_W){1'b0}}, bitrev16(crc_state[HALF_W-1:0])};
  end

  always_comb begin
    if (cfg.is_csum)      result = {{(FULL_W-HALF_W){1'b0}}, csum_final};
    else if (cfg.xor_out) result = refl_val ^ width_mask;
    else                  result = refl_val;
  end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_eng_pkg::*;
#(
  parameter logic [HALF_W-1:0] POLY16_IBM   = 16'h8005,
  parameter logic [HALF_W-1:0] POLY16_CCITT = 16'h1021,
  parameter logic [FULL_W-1:0] POLY32_STD   = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_en,
  input  logic              start,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_refl_in,
  input  logic              cfg_refl_out,
  input  logic              cfg_xor_out,
  input  logic [FULL_W-1:0] poly_a,
  input  logic [FULL_W-1:0] poly_b,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  output logic [FULL_W-1:0] result,
  output logic              result_valid
);

  localparam crc_cfg_t RESET_CFG = decode_cfg(3'b000, 1'b0, 1'b0, 1'b0, '0, '0,
                                              POLY16_IBM, POLY16_CCITT, POLY32_STD);

  // Named events, visible to the bound checker.
  logic              seed_evt;
  logic              accept_evt;
  logic              done_evt;
  crc_cfg_t          cfg_next;
  crc_cfg_t          cfg_q;
  logic              cfg_wide;
  logic [BYTE_W-1:0] crc_din;
  logic [FULL_W-1:0] crc_state;
  logic [HALF_W-1:0] csum_sum;
  logic              csum_odd;
  logic [HALF_W-1:0] csum_final;
  logic              result_valid_q;

  assign seed_evt   = crc_en & start;
  assign accept_evt = crc_en & byte_valid & ~start;
  assign done_evt   = accept_evt & byte_last;

  assign cfg_next = decode_cfg(cfg_mode, cfg_refl_in, cfg_refl_out, cfg_xor_out,
                               poly_a, poly_b, POLY16_IBM, POLY16_CCITT, POLY32_STD);

  crc_cfg_latch #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_evt),
    .cfg_d (cfg_next),
    .cfg_q (cfg_q)
  );

  assign cfg_wide = cfg_q.wide;
  assign crc_din  = cfg_q.refl_in ? bitrev8(byte_data) : byte_data;

  crc_shift_lane u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed      (seed_evt),
    .seed_wide (cfg_next.wide),
    .step      (accept_evt),
    .wide      (cfg_q.wide),
    .poly      (cfg_q.poly),
    .din       (crc_din),
    .state_q   (crc_state)
  );

  csum_lane u_csum (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed      (seed_evt),
    .step      (accept_evt),
    .din       (byte_data),
    .sum_q     (csum_sum),
    .odd_q     (csum_odd),
    .final_sum (csum_final)
  );

  crc_result_shaper u_shape (
    .cfg        (cfg_q),
    .crc_state  (crc_state),
    .csum_final (csum_final),
    .result     (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_valid_q <= 1'b0;
    else        result_valid_q <= done_evt;
  end

  assign result_valid = result_valid_q;

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
  import crc_eng_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        crc_en,
  input logic                        start,
  input logic                        byte_valid,
  input logic                        byte_last,
  input logic [2:0]                  cfg_mode,
  input logic [FULL_W-1:0]           result,
  input logic                        result_valid,
  input logic                        seed_evt,
  input logic                        cfg_wide,
  input logic [$bits(crc_cfg_t)-1:0] cfg_bits,
  input logic [FULL_W-1:0]           crc_state,
  input logic [HALF_W-1:0]           csum_sum,
  input logic                        csum_odd
);

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_en && byte_valid && byte_last && !start) |=> result_valid); // R9

  AST_VALID_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(crc_en && byte_valid && byte_last && !start)); // R9

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wide |-> (result[FULL_W-1:HALF_W] == '0)); // R7

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    seed_evt |=> (crc_state == (($past(cfg_mode) inside {3'b100, 3'b101, 3'b110})
                                ? 32'hFFFF_FFFF : 32'h0000_FFFF))); // R1

  AST_CSUM_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    seed_evt |=> (csum_sum == '0 && !csum_odd)); // R3

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_evt |=> $stable(cfg_bits)); // R8

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_en |=> ($stable(result) && !result_valid)); // R10

endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .crc_en       (crc_en),
  .start        (start),
  .byte_valid   (byte_valid),
  .byte_last    (byte_last),
  .cfg_mode     (cfg_mode),
  .result       (result),
  .result_valid (result_valid),
  .seed_evt     (seed_evt),
  .cfg_wide     (cfg_wide),
  .cfg_bits     (cfg_q),
  .crc_state    (crc_state),
  .csum_sum     (csum_sum),
  .csum_odd     (csum_odd)
);

// File: tb/crc_engine_tb.sv
module crc_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crc_en = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cfg_mode = 3'b000;
  logic        cfg_refl_in = 1'b0;
  logic        cfg_refl_out = 1'b0;
  logic        cfg_xor_out = 1'b0;
  logic [31:0] poly_a = 32'h1EDC_6F41;
  logic [31:0] poly_b = 32'h741B_8CD7;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        byte_last = 1'b0;
  logic [31:0] result;
  logic        result_valid;

  localparam logic [31:0] PA = 32'h1EDC_6F41;
  localparam logic [31:0] PB = 32'h741B_8CD7;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [7:0] pat [0:15];

  always #4 clk = ~clk;

  crc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .start(start),
    .cfg_mode(cfg_mode), .cfg_refl_in(cfg_refl_in), .cfg_refl_out(cfg_refl_out),
    .cfg_xor_out(cfg_xor_out), .poly_a(poly_a), .poly_b(poly_b),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
    .result(result), .result_valid(result_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bit-serial reference: one data bit at a time, feedback from the top bit.
  function automatic logic [31:0] ref_result(input logic [2:0] md, input bit ri,
                                             input bit ro, input bit xo, input int n);
    int unsigned s;
    int w;
    logic [31:0] poly, mask, r, o;
    logic [7:0] b;
    logic fb;
    if (md == 3'b111) begin
      s = 0;
      for (int i = 0; i < n; i += 2)
        s += {pat[i], (i + 1 < n) ? pat[i+1] : 8'h00};
      while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
      return {16'h0, ~s[15:0]};
    end
    w = (md >= 3'b100) ? 32 : 16;
    mask = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    case (md)
      3'b000: poly = 32'h8005;
      3'b001: poly = 32'h1021;
      3'b010: poly = PA & mask;
      3'b011: poly = PB & mask;
      3'b100: poly = 32'h04C1_1DB7;
      3'b101: poly = PA;
      default: poly = PB;
    endcase
    r = mask;
    for (int i = 0; i < n; i++) begin
      b = pat[i];
      if (ri) b = {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
      for (int j = 7; j >= 0; j--) begin
        fb = r[w-1] ^ b[j];
        r  = (r << 1) & mask;
        if (fb) r = r ^ poly;
      end
    end
    o = r;
    if (ro) begin
      o = 0;
      for (int j = 0; j < w; j++) o[j] = r[w-1-j];
    end
    if (xo) o = o ^ mask;
    return o;
  endfunction

  function automatic string req_tag(input logic [2:0] md, input bit ri, input bit ro,
                                    input bit xo);
    string t;
    if (md == 3'b111) return "R3";
    t = (md == 3'b000 || md == 3'b001 || md == 3'b100) ? "R1" : "R2";
    if (ri) t = {t, " R4"};
    if (ro) t = {t, " R5"};
    if (xo) t = {t, " R6"};
    if (md < 3'b100) t = {t, " R7"};
    return t;
  endfunction

  // Start pulse, then n bytes from pat; gaps insert idle cycles, churn
  // scrambles the configuration inputs once the block has started.
  task automatic run_block(input logic [2:0] md, input bit ri, input bit ro, input bit xo,
                           input int n, input bit gaps, input bit churn,
                           input logic [31:0] anchor, input bit use_anchor);
    logic [31:0] exp;
    string tag;
    exp = use_anchor ? anchor : ref_result(md, ri, ro, xo, n);
    tag = req_tag(md, ri, ro, xo);
    @(negedge clk);
    start = 1'b1; cfg_mode = md; cfg_refl_in = ri; cfg_refl_out = ro; cfg_xor_out = xo;
    poly_a = PA; poly_b = PB;
    byte_valid = 1'b1; byte_data = 8'hA5; byte_last = 1'b1; // dropped: same cycle as start (R8)
    @(negedge clk);
    start = 1'b0;
    if (churn) begin
      cfg_mode = ~md; cfg_refl_in = ~ri; cfg_refl_out = ~ro; cfg_xor_out = ~xo;
      poly_a = ~PA; poly_b = ~PB;
    end
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = pat[i]; byte_last = (i == n - 1);
      @(negedge clk);
      if (gaps && i != n - 1) begin
        byte_valid = 1'b0; byte_last = 1'b1;
        @(negedge clk);
      end
    end
    byte_valid = 1'b0; byte_last = 1'b0;
    check(result_valid === 1'b1, "R9 valid after last", {31'h0, result_valid}, 32'h1);
    check(result === exp, churn ? {tag, " R8 churn"} : tag, result, exp);
    @(negedge clk);
    check(result_valid === 1'b0, "R9 single pulse", {31'h0, result_valid}, 32'h0);
  endtask

  task automatic load_check_string();
    for (int i = 0; i < 9; i++) pat[i] = 8'h31 + 8'(i);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(result_valid === 1'b0, "R9 reset valid", {31'h0, result_valid}, 32'h0);
    check(result === 32'h0, "R7 reset result", result, 32'h0);
    crc_en = 1'b1;

    // Textbook check values over the ASCII digits 1..9.
    load_check_string();
    run_block(3'b000, 0, 0, 0, 9, 0, 0, 32'h0000_AEE7, 1);
    run_block(3'b001, 0, 0, 0, 9, 0, 0, 32'h0000_29B1, 1);
    run_block(3'b100, 0, 0, 0, 9, 0, 0, 32'h0376_E6E7, 1);
    run_block(3'b100, 1, 1, 1, 9, 0, 0, 32'hCBF4_3926, 1);
    run_block(3'b000, 1, 1, 0, 9, 0, 0, 32'h0000_4B37, 1);

    // Checksum corner cases: odd length, end-around carry.
    pat[0] = 8'h01; pat[1] = 8'h02; pat[2] = 8'h03;
    run_block(3'b111, 0, 0, 0, 3, 0, 0, 32'h0000_FBFD, 1);
    run_block(3'b111, 1, 1, 1, 3, 0, 0, 32'h0000_FBFD, 1);
    pat[0] = 8'hFF; pat[1] = 8'hFF; pat[2] = 8'h00; pat[3] = 8'h01;
    run_block(3'b111, 0, 0, 0, 4, 0, 0, 32'h0000_FFFE, 1);

    // Sweep: every mode, every option combination, three patterns.
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int o = 0; o < 8; o++) begin
          if (p == 0) load_check_string();
          else if (p == 1) for (int i = 0; i < 4; i++) pat[i] = 8'((m * 37 + o * 11 + i * 73) ^ 8'h5C);
          else for (int i = 0; i < 7; i++) pat[i] = 8'((i * 29 + m * 3 + o) * 13 + 8'h81);
          run_block(3'(m), o[2], o[1], o[0], (p == 0) ? 9 : (p == 1) ? 4 : 7,
                    p == 1, p == 2, 32'h0, 0);
        end
      end
    end

    // Disabled channel: start and bytes ignored, result held (R10).
    load_check_string();
    run_block(3'b101, 1, 0, 1, 9, 0, 0, 32'h0, 0);
    held = result;
    @(negedge clk);
    crc_en = 1'b0;
    start = 1'b1; cfg_mode = 3'b111;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      byte_valid = 1'b1; byte_data = 8'(i * 17 + 3); byte_last = (i == 3);
      @(negedge clk);
      check(result_valid === 1'b0, "R10 no valid while disabled", {31'h0, result_valid}, 32'h0);
      check(result === held, "R10 result held while disabled", result, held);
    end
    byte_valid = 1'b0; byte_last = 1'b0;
    crc_en = 1'b1;
    @(negedge clk);
    check(result === held, "R10 result held after re-enable", result, held);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule